// File: doc/BRIEF.md
# TF32 Tile Matrix Multiply-Accumulate Engine

This block holds three square tiles of single-precision values: an accumulator tile C and two source tiles A and B. A start pulse begins the operation C = C + A×B. When the transpose input is high at start, the operation is C = C + Aᵀ×B instead. Before any element of A or B reaches the multiplier it is reduced to TF32 precision. A signalling NaN is first made quiet, and then the thirteen least significant mantissa bits are cleared. One shared single-precision multiplier and one shared adder do the arithmetic, one multiply-accumulate per clock.

Software, or a neighbouring load/store unit, fills the tiles through a word-addressed port while the engine is idle. That port gives a tile select, a row, a column and a data word. The caller then supplies the active row count M, column count N and inner depth K and pulses start. While the operation runs, busy is high. A one-cycle done pulse marks the end. The result is read back through the same port. For each output row, the products are summed into a temporary row that starts at zero. The old accumulator row is added only after all K products have been summed. Unused columns and rows of C are cleared.

Top module: `tf32_tile_mac`

## Requirements
- R1: After reset, busy and done are low and every element of all three tiles reads as zero.
- R2: Each A and B element enters the multiplier with bits [12:0] cleared and bits [31:13] unchanged.
- R3: An A or B element with exponent 255, a nonzero fraction and fraction bit 22 clear has bit 22 set before truncation, so it acts as a quiet NaN rather than an infinity.
- R4: With transpose low, element C[m][n] for m<M and n<N becomes C[m][n] + Σk A[m][k]·B[k][n]. The products are summed from zero in order of k, and the old C[m][n] is added last.
- R5: With transpose high, A is read as A[k][m], so C[m][n] becomes C[m][n] + Σk A[k][m]·B[k][n], with the same summation order as R4.
- R6: In rows m<M, every column at or above N reads zero after the operation.
- R7: Every row at or above M reads zero after the operation.
- R8: When M, N and K are all nonzero, done is a single-cycle pulse that arrives M·(K·N+N) clock edges after the edge that samples start. Busy is high from the start edge until done rises.
- R9: A start pulse while busy is high has no effect on the running operation or on its result.
- R10: A tile write while busy is high is dropped.
- R11: If M, N or K is zero, the only effect is that rows at or above M are cleared, and done is high right after the start edge.
- R12: Multiply and add round to nearest-even. Subnormal inputs and results are treated as signed zero, overflow gives a signed infinity, and every NaN result is exactly 0x7FC00000.
- R13: Tile select 0 addresses C, 1 addresses A and 2 addresses B. Select 3 reads zero and ignores writes. Reads are combinational. Counts above 16 are treated as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| transpose | input | 1 | 1 selects Aᵀ×B, 0 selects A×B |
| cfg_rows | input | 5 | Active row count M |
| cfg_cols | input | 5 | Active column count N |
| cfg_depth | input | 5 | Inner depth K |
| tile_wr_en | input | 1 | Write strobe for the tile port |
| tile_sel | input | 2 | Tile select: 0 = C, 1 = A, 2 = B, 3 = none |
| tile_row | input | 4 | Row index |
| tile_col | input | 4 | Column index |
| tile_wdata | input | 32 | Write data |
| tile_rdata | output | 32 | Read data for the addressed element |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Integer test data would sum exactly whatever the order, so it cannot show that the old accumulator is added last. To expose the order, the stimulus loads two products of +2^24 and −2^24 and an accumulator value of 1.0. Only the required order returns exactly 1.0; adding the accumulator first rounds it away. The bench also issues a second start and tile writes in the middle of a run. It then checks that both the latency and the result follow the first command, and that the A tile reads back unchanged.

// File: rtl/tf32_pkg.sv
package tf32_pkg;
    localparam int unsigned FP_W = 32;
    localparam logic [FP_W-1:0] CANON_NAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_WB   = 2'd2
    } eng_state_e;

    typedef enum logic [1:0] {
        SEL_ACC  = 2'd0,
        SEL_SRCA = 2'd1,
        SEL_SRCB = 2'd2,
        SEL_NONE = 2'd3
    } tile_sel_e;
endpackage

// File: rtl/tf32_condition.sv
module tf32_condition (
    input  logic [31:0] raw,
    output logic [31:0] cond
);
    logic snan;

    // exponent all ones, fraction nonzero, quiet bit clear
    assign snan = (raw[30:23] == 8'hFF) && (raw[22:0] != 23'd0) && !raw[22];
    assign cond = {raw[31:23], raw[22] | snan, raw[21:13], 13'd0};
endmodule

// File: rtl/fp32_mul.sv
module fp32_mul (
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic [31:0] prod
);
    import tf32_pkg::*;

    logic               sgn, a_nan, a_inf, a_zero, b_nan, b_inf, b_zero;
    logic [23:0]        ma, mb;
    logic [47:0]        full;
    logic [24:0]        mant;
    logic               rg, rs;
    logic signed [9:0]  ex;

    always_comb begin
        sgn    = op_a[31] ^ op_b[31];
        a_nan  = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 23'd0);
        a_inf  = (op_a[30:23] == 8'hFF) && (op_a[22:0] == 23'd0);
        a_zero = (op_a[30:23] == 8'h00);
        b_nan  = (op_b[30:23] == 8'hFF) && (op_b[22:0] != 23'd0);
        b_inf  = (op_b[30:23] == 8'hFF) && (op_b[22:0] == 23'd0);
        b_zero = (op_b[30:23] == 8'h00);
        ma     = {1'b1, op_a[22:0]};
        mb     = {1'b1, op_b[22:0]};
        full   = 48'(ma) * 48'(mb);
        ex     = $signed({2'b00, op_a[30:23]}) + $signed({2'b00, op_b[30:23]}) - 10'sd127;
        if (full[47]) begin
            mant = {1'b0, full[47:24]};
            rg   = full[23];
            rs   = |full[22:0];
            ex   = ex + 10'sd1;
        end else begin
            mant = {1'b0, full[46:23]};
            rg   = full[22];
            rs   = |full[21:0];
        end
        if (rg && (rs || mant[0])) mant = mant + 25'd1;
        if (mant[24]) begin
            mant = mant >> 1;
            ex   = ex + 10'sd1;
        end
        if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero))
            prod = CANON_NAN;
        else if (a_inf || b_inf)
            prod = {sgn, 8'hFF, 23'd0};
        else if (a_zero || b_zero)
            prod = {sgn, 31'd0};
        else if (ex >= 10'sd255)
            prod = {sgn, 8'hFF, 23'd0};
        else if (ex <= 10'sd0)
            prod = {sgn, 31'd0};
        else
            prod = {sgn, ex[7:0], mant[22:0]};
    end
endmodule

// File: rtl/fp32_add.sv
module fp32_add (
    input  logic [31:0] op_x,
    input  logic [31:0] op_y,
    output logic [31:0] sum
);
    import tf32_pkg::*;

    logic               x_nan, x_inf, x_zero, y_nan, y_inf, y_zero, swap;
    logic [31:0]        big, sml;
    logic [26:0]        mb27, ms27, sm27, norm27;
    logic [7:0]         dexp;
    logic [4:0]         dcl, lz;
    logic [52:0]        ext;
    logic [27:0]        raw28;
    logic [24:0]        mant;
    logic               rg, rs;
    logic signed [9:0]  ex;

    always_comb begin
        x_nan  = (op_x[30:23] == 8'hFF) && (op_x[22:0] != 23'd0);
        x_inf  = (op_x[30:23] == 8'hFF) && (op_x[22:0] == 23'd0);
        x_zero = (op_x[30:23] == 8'h00);
        y_nan  = (op_y[30:23] == 8'hFF) && (op_y[22:0] != 23'd0);
        y_inf  = (op_y[30:23] == 8'hFF) && (op_y[22:0] == 23'd0);
        y_zero = (op_y[30:23] == 8'h00);
        swap   = op_y[30:0] > op_x[30:0];
        big    = swap ? op_y : op_x;
        sml    = swap ? op_x : op_y;
        mb27   = {1'b1, big[22:0], 3'b000};
        ms27   = {1'b1, sml[22:0], 3'b000};
        dexp   = big[30:23] - sml[30:23];
        dcl    = (dexp > 8'd31) ? 5'd31 : dexp[4:0];
        ext    = {ms27, 26'd0} >> dcl;
        sm27   = {ext[52:27], ext[26] | (|ext[25:0])};
        if (big[31] ^ sml[31]) raw28 = {1'b0, mb27} - {1'b0, sm27};
        else                   raw28 = {1'b0, mb27} + {1'b0, sm27};
        ex = $signed({2'b00, big[30:23]});
        lz = 5'd0;
        for (int i = 0; i < 27; i++) begin
            if (raw28[i]) lz = 5'(26 - i);
        end
        if (raw28[27]) begin
            norm27 = {raw28[27:2], raw28[1] | raw28[0]};
            ex     = ex + 10'sd1;
        end else begin
            norm27 = raw28[26:0] << lz;
            ex     = ex - $signed({5'd0, lz});
        end
        mant = {1'b0, norm27[26:3]};
        rg   = norm27[2];
        rs   = |norm27[1:0];
        if (rg && (rs || mant[0])) mant = mant + 25'd1;
        if (mant[24]) begin
            mant = mant >> 1;
            ex   = ex + 10'sd1;
        end
        if (x_nan || y_nan || (x_inf && y_inf && (op_x[31] != op_y[31])))
            sum = CANON_NAN;
        else if (x_inf)
            sum = op_x;
        else if (y_inf)
            sum = op_y;
        else if (x_zero && y_zero)
            sum = {op_x[31] & op_y[31], 31'd0};
        else if (x_zero)
            sum = op_y;
        else if (y_zero)
            sum = op_x;
        else if (raw28 == 28'd0)
            sum = 32'd0;
        else if (ex >= 10'sd255)
            sum = {big[31], 8'hFF, 23'd0};
        else if (ex <= 10'sd0)
            sum = {big[31], 31'd0};
        else
            sum = {big[31], ex[7:0], mant[22:0]};
    end
endmodule

// File: rtl/tf32_tile_mac.sv
module tf32_tile_mac #(
    parameter int unsigned DIM = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         transpose,
    input  logic [$clog2(DIM+1)-1:0]     cfg_rows,
    input  logic [$clog2(DIM+1)-1:0]     cfg_cols,
    input  logic [$clog2(DIM+1)-1:0]     cfg_depth,
    input  logic                         tile_wr_en,
    input  logic [1:0]                   tile_sel,
    input  logic [$clog2(DIM)-1:0]       tile_row,
    input  logic [$clog2(DIM)-1:0]       tile_col,
    input  logic [31:0]                  tile_wdata,
    output logic [31:0]                  tile_rdata,
    output logic                         busy,
    output logic                         done
);
    import tf32_pkg::*;

    localparam int unsigned IDX_W = $clog2(DIM);
    localparam int unsigned CNT_W = $clog2(DIM + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIM);

    typedef logic [DIM-1:0][DIM-1:0][31:0] tile_t;
    typedef logic [DIM-1:0][31:0]          row_t;

    typedef struct packed {
        eng_state_e       st;
        logic             trn;
        logic [CNT_W-1:0] m_lim, n_lim, k_lim;
        logic [IDX_W-1:0] m, k, n;
        logic             fin;
        row_t             tmp;
        tile_t            tc, ta, tb;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [31:0]      a_raw, b_raw, a_cnd, b_cnd, prod, add_y, sum_res;
    logic [CNT_W-1:0] m_nx, n_nx, k_nx, lim_m, lim_n, lim_k;

    assign a_raw = eng_q.trn ? eng_q.ta[eng_q.k][eng_q.m] : eng_q.ta[eng_q.m][eng_q.k];
    assign b_raw = eng_q.tb[eng_q.k][eng_q.n];

    tf32_condition u_cond_a (.raw(a_raw), .cond(a_cnd));
    tf32_condition u_cond_b (.raw(b_raw), .cond(b_cnd));
    fp32_mul       u_mul    (.op_a(a_cnd), .op_b(b_cnd), .prod(prod));

    // shared adder: products during accumulation, old row during write-back
    assign add_y = (eng_q.st == ST_WB) ? eng_q.tc[eng_q.m][eng_q.n] : prod;
    fp32_add       u_add    (.op_x(eng_q.tmp[eng_q.n]), .op_y(add_y), .sum(sum_res));

    assign m_nx  = CNT_W'(eng_q.m) + CNT_W'(1);
    assign n_nx  = CNT_W'(eng_q.n) + CNT_W'(1);
    assign k_nx  = CNT_W'(eng_q.k) + CNT_W'(1);
    assign lim_m = (cfg_rows  > CNT_MAX) ? CNT_MAX : cfg_rows;
    assign lim_n = (cfg_cols  > CNT_MAX) ? CNT_MAX : cfg_cols;
    assign lim_k = (cfg_depth > CNT_MAX) ? CNT_MAX : cfg_depth;

    always_comb begin
        eng_d     = eng_q;
        eng_d.fin = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (tile_wr_en) begin
                    case (tile_sel)
                        SEL_ACC:  eng_d.tc[tile_row][tile_col] = tile_wdata;
                        SEL_SRCA: eng_d.ta[tile_row][tile_col] = tile_wdata;
                        SEL_SRCB: eng_d.tb[tile_row][tile_col] = tile_wdata;
                        default:  ;
                    endcase
                end
                if (start) begin
                    eng_d.trn   = transpose;
                    eng_d.m_lim = lim_m;
                    eng_d.n_lim = lim_n;
                    eng_d.k_lim = lim_k;
                    eng_d.m     = '0;
                    eng_d.k     = '0;
                    eng_d.n     = '0;
                    eng_d.tmp   = '0;
                    if (lim_m == '0 || lim_n == '0 || lim_k == '0) begin
                        for (int r = 0; r < int'(DIM); r++)
                            if (r >= int'(lim_m)) eng_d.tc[r] = '0;
                        eng_d.fin = 1'b1;
                    end else begin
                        eng_d.st = ST_MAC;
                    end
                end
            end
            ST_MAC: begin
                eng_d.tmp[eng_q.n] = sum_res;
                if (n_nx == eng_q.n_lim) begin
                    eng_d.n = '0;
                    if (k_nx == eng_q.k_lim) begin
                        eng_d.k  = '0;
                        eng_d.st = ST_WB;
                    end else begin
                        eng_d.k = eng_q.k + IDX_W'(1);
                    end
                end else begin
                    eng_d.n = eng_q.n + IDX_W'(1);
                end
            end
            ST_WB: begin
                eng_d.tc[eng_q.m][eng_q.n] = sum_res;
                if (n_nx == eng_q.n_lim) begin
                    for (int c = 0; c < int'(DIM); c++)
                        if (c >= int'(eng_q.n_lim)) eng_d.tc[eng_q.m][c] = '0;
                    eng_d.n   = '0;
                    eng_d.tmp = '0;
                    if (m_nx == eng_q.m_lim) begin
                        for (int r = 0; r < int'(DIM); r++)
                            if (r >= int'(eng_q.m_lim)) eng_d.tc[r] = '0;
                        eng_d.st  = ST_IDLE;
                        eng_d.fin = 1'b1;
                    end else begin
                        eng_d.m  = eng_q.m + IDX_W'(1);
                        eng_d.st = ST_MAC;
                    end
                end else begin
                    eng_d.n = eng_q.n + IDX_W'(1);
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    always_comb begin
        case (tile_sel)
            SEL_ACC:  tile_rdata = eng_q.tc[tile_row][tile_col];
            SEL_SRCA: tile_rdata = eng_q.ta[tile_row][tile_col];
            SEL_SRCB: tile_rdata = eng_q.tb[tile_row][tile_col];
            default:  tile_rdata = 32'd0;
        endcase
    end

    assign busy = (eng_q.st != ST_IDLE);
    assign done = eng_q.fin;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(eng_q.trn) && $stable(eng_q.m_lim) && $stable(eng_q.k_lim))); // R9
    AST_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tile_wr_en) |=> ($stable(eng_q.ta) && $stable(eng_q.tb))); // R10
    AST_ZERO_DIM: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (lim_m == '0 || lim_n == '0 || lim_k == '0)) |=> done); // R11
    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (CNT_W'(eng_q.n) < eng_q.n_lim)); // R4
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sum_res[30:23] == 8'hFF && sum_res[22:0] != 23'd0) |-> (sum_res == CANON_NAN)); // R12
endmodule

// File: tb/tf32_tile_mac_bench.sv
module tf32_tile_mac_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        transpose = 1'b0;
    logic [4:0]  cfg_rows = '0, cfg_cols = '0, cfg_depth = '0;
    logic        tile_wr_en = 1'b0;
    logic [1:0]  tile_sel = '0;
    logic [3:0]  tile_row = '0, tile_col = '0;
    logic [31:0] tile_wdata = '0;
    logic [31:0] tile_rdata;
    logic        busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tf32_tile_mac u_tf32_tile_mac (
        .clk(clk), .rst_n(rst_n), .start(start), .transpose(transpose),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_depth(cfg_depth),
        .tile_wr_en(tile_wr_en), .tile_sel(tile_sel), .tile_row(tile_row),
        .tile_col(tile_col), .tile_wdata(tile_wdata), .tile_rdata(tile_rdata),
        .busy(busy), .done(done)
    );

    // M, N, K, transpose, seed
    localparam int NCASE = 6;
    localparam logic [19:0] CASES [NCASE] = '{
        {5'd16, 5'd16, 5'd16, 1'b0, 4'd1},
        {5'd16, 5'd16, 5'd16, 1'b1, 4'd2},
        {5'd3,  5'd5,  5'd4,  1'b0, 4'd3},
        {5'd5,  5'd3,  5'd7,  1'b1, 4'd4},
        {5'd1,  5'd16, 5'd1,  1'b0, 4'd5},
        {5'd7,  5'd9,  5'd2,  1'b1, 4'd6}
    };

    function automatic logic [31:0] i2f(int v);
        int a, p;
        logic s;
        if (v == 0) return 32'd0;
        s = (v < 0);
        a = s ? -v : v;
        p = 0;
        for (int i = 0; i < 31; i++) if ((a >> i) & 1) p = i;
        return {s, 8'(127 + p), 23'((a << (23 - p)) & 32'h7FFFFF)};
    endfunction

    function automatic int pa(int r, int c, int s); return ((r*3 + c*5 + s) % 7) - 3; endfunction
    function automatic int pb(int r, int c, int s); return ((r*5 + c*3 + 2*s) % 9) - 4; endfunction
    function automatic int pd(int r, int c, int s); return ((r + 2*c + s) % 5) + 1; endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, int r, int c, logic [31:0] d);
        tile_sel = sel; tile_row = 4'(r); tile_col = 4'(c); tile_wdata = d; tile_wr_en = 1'b1;
        @(posedge clk); #1;
        tile_wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, int r, int c, output logic [31:0] d);
        @(posedge clk); #1;
        tile_sel = sel; tile_row = 4'(r); tile_col = 4'(c);
        #1 d = tile_rdata;
    endtask

    task automatic load_pattern(int s);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) begin
                wr(2'd0, r, c, i2f(pd(r, c, s)));
                wr(2'd1, r, c, i2f(pa(r, c, s)));
                wr(2'd2, r, c, i2f(pb(r, c, s)));
            end
    endtask

    // start the engine and count edges after the start edge until done
    task automatic run(int m, int n, int k, bit t, string tag, int exp_cnt);
        int cnt;
        cfg_rows = 5'(m); cfg_cols = 5'(n); cfg_depth = 5'(k); transpose = t; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 20000) begin
            @(posedge clk); #1;
            cnt++;
        end
        chk({tag, " R8 latency"}, 32'(cnt), 32'(exp_cnt));
        @(posedge clk); #1;
        chk({tag, " R8 done pulse"}, {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk); #1;
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < 16; r += 5)
                for (int c = 0; c < 16; c += 5) begin
                    rd(2'(s), r, c, v);
                    chk("R1 tile zero", v, 32'd0);
                end
        // R13 select 3 ignores writes and reads zero
        wr(2'd3, 2, 3, 32'hDEADBEEF);
        rd(2'd3, 2, 3, v); chk("R13 sel3 read", v, 32'd0);
        for (int s = 0; s < 3; s++) begin
            rd(2'(s), 2, 3, v); chk("R13 sel3 write ignored", v, 32'd0);
        end

        // table of multiply cases: R4 R5 R6 R7 R8
        for (int ci = 0; ci < NCASE; ci++) begin
            int m, n, k, s;
            bit t;
            m = int'(CASES[ci][19:15]); n = int'(CASES[ci][14:10]);
            k = int'(CASES[ci][9:5]);   t = CASES[ci][4];  s = int'(CASES[ci][3:0]);
            load_pattern(s);
            run(m, n, k, t, "R4/R5 table", m * (k * n + n));
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 16; c++) begin
                    int acc;
                    acc = 0;
                    if (r < m && c < n) begin
                        for (int kk = 0; kk < k; kk++)
                            acc += (t ? pa(kk, r, s) : pa(r, kk, s)) * pb(kk, c, s);
                        acc += pd(r, c, s);
                    end
                    rd(2'd0, r, c, v);
                    if (r >= m)      chk("R7 upper row zero", v, 32'd0);
                    else if (c >= n) chk("R6 trailing column zero", v, 32'd0);
                    else             chk(t ? "R5 transposed result" : "R4 normal result", v, i2f(acc));
                end
        end

        // R4 order: products summed from zero, old value added last
        wr(2'd0, 0, 0, 32'h3F800000);
        wr(2'd1, 0, 0, 32'h45800000); wr(2'd1, 0, 1, 32'hC5800000);
        wr(2'd2, 0, 0, 32'h45800000); wr(2'd2, 1, 0, 32'h45800000);
        run(1, 1, 2, 1'b0, "R4 order", 3);
        rd(2'd0, 0, 0, v); chk("R4 accumulator added last", v, 32'h3F800000);

        // R2 truncation
        wr(2'd0, 0, 0, 32'd0); wr(2'd1, 0, 0, 32'h3FFFFFFF); wr(2'd2, 0, 0, 32'h3F800000);
        run(1, 1, 1, 1'b0, "R2", 2);
        rd(2'd0, 0, 0, v); chk("R2 low mantissa cleared", v, 32'h3FFFE000);

        // R3 signalling NaN quieted (truncation alone would give infinity)
        wr(2'd0, 0, 0, 32'd0); wr(2'd1, 0, 0, 32'h7F800001);
        run(1, 1, 1, 1'b0, "R3", 2);
        rd(2'd0, 0, 0, v); chk("R3 sNaN quieted R12 canonical", v, 32'h7FC00000);

        // R12 canonical NaN from a payload NaN
        wr(2'd0, 0, 0, 32'd0); wr(2'd1, 0, 0, 32'hFFC12345);
        run(1, 1, 1, 1'b0, "R12", 2);
        rd(2'd0, 0, 0, v); chk("R12 NaN canonical", v, 32'h7FC00000);

        // R12 round to nearest even: 1.0 + (1+2^-23)
        wr(2'd0, 0, 0, 32'h3F800001); wr(2'd1, 0, 0, 32'h3F800000);
        run(1, 1, 1, 1'b0, "R12", 2);
        rd(2'd0, 0, 0, v); chk("R12 tie to even", v, 32'h40000000);

        // R12 subnormal flushed
        wr(2'd0, 0, 0, 32'h00000001); wr(2'd1, 0, 0, 32'h00000000);
        run(1, 1, 1, 1'b0, "R12", 2);
        rd(2'd0, 0, 0, v); chk("R12 subnormal flush", v, 32'h00000000);

        // R12 overflow to infinity
        wr(2'd0, 0, 0, 32'd0); wr(2'd1, 0, 0, 32'h7F000000); wr(2'd2, 0, 0, 32'h40000000);
        run(1, 1, 1, 1'b0, "R12", 2);
        rd(2'd0, 0, 0, v); chk("R12 overflow infinity", v, 32'h7F800000);

        // R9 R10: second start and writes while busy
        begin
            int cnt;
            load_pattern(7);
            cfg_rows = 5'd2; cfg_cols = 5'd2; cfg_depth = 5'd2; transpose = 1'b0; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            @(posedge clk); #1;
            chk("R8 busy during run", {31'd0, busy}, 32'd1);
            start = 1'b1; transpose = 1'b1; cfg_rows = 5'd16; cfg_cols = 5'd16; cfg_depth = 5'd16;
            tile_sel = 2'd1; tile_row = 4'd0; tile_col = 4'd0; tile_wdata = 32'h12345678; tile_wr_en = 1'b1;
            @(posedge clk); #1;
            start = 1'b0; tile_wr_en = 1'b0;
            cnt = 2;
            while (!done && cnt < 20000) begin
                @(posedge clk); #1;
                cnt++;
            end
            chk("R9 latency unchanged by second start", 32'(cnt), 32'd12);
            for (int r = 0; r < 2; r++)
                for (int c = 0; c < 2; c++) begin
                    int acc;
                    acc = pd(r, c, 7);
                    for (int kk = 0; kk < 2; kk++) acc += pa(r, kk, 7) * pb(kk, c, 7);
                    rd(2'd0, r, c, v); chk("R9 result follows first start", v, i2f(acc));
                end
            rd(2'd0, 2, 0, v); chk("R9 R7 row 2 cleared", v, 32'd0);
            rd(2'd1, 0, 0, v); chk("R10 write while busy dropped", v, i2f(pa(0, 0, 7)));
        end

        // R11 zero dimension: rows >= M cleared, others untouched, done at once
        load_pattern(8);
        run(3, 0, 4, 1'b0, "R11", 0);
        rd(2'd0, 0, 0, v);  chk("R11 row0 kept", v, i2f(pd(0, 0, 8)));
        rd(2'd0, 2, 15, v); chk("R11 row2 kept", v, i2f(pd(2, 15, 8)));
        rd(2'd0, 3, 0, v);  chk("R11 row3 cleared", v, 32'd0);
        rd(2'd0, 15, 9, v); chk("R11 row15 cleared", v, 32'd0);
        rd(2'd1, 5, 5, v);  chk("R11 A untouched", v, i2f(pa(5, 5, 8)));

        // R13 counts above 16 act as 16: M=0 check via K=0 and M=31
        load_pattern(9);
        run(31, 5, 0, 1'b0, "R13 clamp", 0);
        rd(2'd0, 15, 3, v); chk("R13 clamped row count keeps row 15", v, i2f(pd(15, 3, 9)));

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule